// File: doc/BRIEF.md
# Overlapped Two-Controller Insertion Sorter

The block holds up to `DEPTH` unsigned words in an internal register file and sorts the first N of them into ascending order in place. A host fills the register file through a load port while the block is idle, writes the element count on `count`, and pulses `start`. The sorter raises `busy` while it works, pulses `done` once it has finished, and the host then reads the result word by word through a combinational read port.

Two cooperating state machines do the work. An outer controller walks the element index, fetches each new key and commits the previous key to its final slot. An inner controller runs the shift loop. The shift loop is a two-stage pipeline: a compare stage reads a word and tests it against the key, and the next stage writes that word one slot higher while the compare stage already reads the word below it. The inner controller reports its exit condition combinationally. This lets the outer controller commit the old key, set up the next index, fetch the next key and launch the next shift loop all in one cycle. The run time therefore depends on the data: each element costs two cycles plus one cycle per larger element it passes.

Top module: `insertion_sorter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy` and `done` are 0.
- R2: While `busy` is 0, a cycle with `ld_en` high writes `ld_data` into word `ld_addr`. While `busy` is 0, `rd_data` always shows the word at `rd_addr` in the same cycle.
- R3: A `start` pulse while idle sorts words 0..N-1 into ascending unsigned order, where N is the value of `count` at that edge. After `done`, words N..DEPTH-1 are unchanged.
- R4: A word moves up only when it is strictly greater than the key. Equal values therefore never pass each other and add no cycles.
- R5: After the start edge, `busy` is high for exactly 1 + 2(N-1) + I cycles, where I is the number of index pairs p<q with word p greater than word q. For N of 0 or 1, `busy` is high for exactly 1 cycle.
- R6: `done` is high for exactly one cycle: the first cycle in which `busy` is low again after a sort. `done` is never high together with `busy`.
- R7: While `busy` is high, `start` and `ld_en` have no effect on the result or on the timing.
- R8: A `count` above `DEPTH` is treated as `DEPTH`.
- R9: The register file takes at most one write per cycle. Every word written by the shift stage is strictly greater than the key being inserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Host write strobe (used only when idle) |
| ld_addr | input | AW | Host write address |
| ld_data | input | WIDTH | Host write data |
| count | input | AW+1 | Number of words to sort, sampled on start |
| start | input | 1 | Start pulse |
| busy | output | 1 | Sort in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_addr | input | AW | Host read address |
| rd_data | output | WIDTH | Word at rd_addr (valid when idle) |

## Verification
The hardest cases to reach from the ports are those where one shift loop ends and the commit, the next fetch and the next launch all fall into the same cycle. Another is a shift run that moves a word all the way down to slot 0. Both cases show up only as an exact busy length and as the final contents. The bench therefore compares `busy` and `done` on every clock against a latency predicted from the inversion count. It uses reverse-ordered, already-ordered, duplicate-heavy and random data, and it includes N of 0 and 1. A run with `start` and a load strobe injected mid-sort confirms that both are ignored.

// File: rtl/sorter_pkg.sv
package sorter_pkg;
  typedef enum logic [1:0] {
    OST_IDLE = 2'd0,
    OST_STEP = 2'd1,
    OST_WAIT = 2'd2
  } outer_st_t;

  typedef enum logic {
    IST_IDLE = 1'b0,
    IST_RUN  = 1'b1
  } inner_st_t;
endpackage

// File: rtl/sort_regfile.sv
module sort_regfile #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] word_q [DEPTH];

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic sel;
    assign sel = we && (waddr == AW'(w));
    always_ff @(posedge clk) begin
      if (sel) word_q[w] <= wdata;
    end
  end

  assign rdata = word_q[raddr];
endmodule

// File: rtl/sort_inner_ctl.sv
module sort_inner_ctl
  import sorter_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int AW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [AW-1:0]    base,
  input  logic [WIDTH-1:0] key,
  input  logic [WIDTH-1:0] rdata,
  output logic             rd_active,
  output logic [AW-1:0]    raddr,
  output logic             sh_we,
  output logic [AW-1:0]    sh_addr,
  output logic [WIDTH-1:0] sh_data,
  output logic [AW-1:0]    wa,
  output logic             done
);
  inner_st_t        st_q, st_d;
  logic [AW:0]      ri_q, ri_d;
  logic             shv_q, shv_d;
  logic [AW-1:0]    sha_q, wa_q;
  logic [WIDTH-1:0] shd_q;
  logic             run, idx_ok, hit;

  assign run    = (st_q == IST_RUN);
  assign idx_ok = ~ri_q[AW];
  assign hit    = run && idx_ok && (key < rdata);
  assign done   = !run || !hit;

  always_comb begin
    st_d  = st_q;
    ri_d  = ri_q;
    shv_d = 1'b0;
    case (st_q)
      IST_IDLE: begin
        if (go) begin
          st_d = IST_RUN;
          ri_d = {1'b0, base};
        end
      end
      IST_RUN: begin
        if (hit) begin
          ri_d  = ri_q - (AW+1)'(1);
          shv_d = 1'b1;
        end else begin
          st_d = IST_IDLE;
        end
      end
      default: st_d = IST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= IST_IDLE;
      ri_q  <= '0;
      shv_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ri_q  <= ri_d;
      shv_q <= shv_d;
    end
  end

  always_ff @(posedge clk) begin
    if (hit) begin
      sha_q <= ri_q[AW-1:0] + AW'(1);
      shd_q <= rdata;
    end
    if (run && !hit) wa_q <= ri_q[AW-1:0] + AW'(1);
  end

  assign rd_active = run;
  assign raddr     = ri_q[AW-1:0];
  assign sh_we     = shv_q;
  assign sh_addr   = sha_q;
  assign sh_data   = shd_q;
  assign wa        = wa_q;
endmodule

// File: rtl/sort_outer_ctl.sv
module sort_outer_ctl
  import sorter_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int CW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CW-1:0]    count,
  input  logic [WIDTH-1:0] rdata,
  input  logic             inner_done,
  input  logic [AW-1:0]    wa,
  output logic             busy,
  output logic             done,
  output logic             fetch,
  output logic [AW-1:0]    fetch_addr,
  output logic             inner_go,
  output logic [AW-1:0]    inner_base,
  output logic             commit_we,
  output logic [AW-1:0]    commit_addr,
  output logic [WIDTH-1:0] key
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  outer_st_t        st_q, st_d;
  logic [CW-1:0]    j_q, j_d, n_q, n_d;
  logic             pend_q, pend_d, done_q, done_d;
  logic             key_en;
  logic [WIDTH-1:0] key_q;

  always_comb begin
    st_d      = st_q;
    j_d       = j_q;
    n_d       = n_q;
    pend_d    = pend_q;
    done_d    = 1'b0;
    key_en    = 1'b0;
    fetch     = 1'b0;
    inner_go  = 1'b0;
    commit_we = 1'b0;
    case (st_q)
      OST_IDLE: begin
        if (start) begin
          st_d   = OST_STEP;
          j_d    = CW'(1);
          n_d    = (count > DEPTH_C) ? DEPTH_C : count;
          pend_d = 1'b0;
        end
      end
      OST_STEP: begin
        commit_we = pend_q;
        if (j_q < n_q) begin
          fetch    = 1'b1;
          key_en   = 1'b1;
          inner_go = 1'b1;
          j_d      = j_q + CW'(1);
          pend_d   = 1'b1;
          st_d     = OST_WAIT;
        end else begin
          pend_d = 1'b0;
          done_d = 1'b1;
          st_d   = OST_IDLE;
        end
      end
      OST_WAIT: begin
        if (inner_done) st_d = OST_STEP;
      end
      default: st_d = OST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= OST_IDLE;
      j_q    <= '0;
      n_q    <= '0;
      pend_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      j_q    <= j_d;
      n_q    <= n_d;
      pend_q <= pend_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk) begin
    if (key_en) key_q <= rdata;
  end

  assign busy        = (st_q != OST_IDLE);
  assign done        = done_q;
  assign fetch_addr  = j_q[AW-1:0];
  assign inner_base  = j_q[AW-1:0] - AW'(1);
  assign commit_addr = wa;
  assign key         = key_q;
endmodule

// File: rtl/insertion_sorter.sv
module insertion_sorter #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [AW-1:0]    ld_addr,
  input  logic [WIDTH-1:0] ld_data,
  input  logic [CW-1:0]    count,
  input  logic             start,
  output logic             busy,
  output logic             done,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);
  logic             fetch, inner_go, commit_we, inner_run, inner_done;
  logic             sh_we, host_we, mem_we;
  logic [AW-1:0]    fetch_addr, inner_base, commit_addr, inner_raddr;
  logic [AW-1:0]    sh_addr, wa, mem_waddr, mem_raddr;
  logic [WIDTH-1:0] key, sh_data, mem_wdata, mem_rdata;

  sort_outer_ctl #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW), .CW(CW)) u_outer (
    .clk(clk), .rst_n(rst_n), .start(start), .count(count),
    .rdata(mem_rdata), .inner_done(inner_done), .wa(wa),
    .busy(busy), .done(done), .fetch(fetch), .fetch_addr(fetch_addr),
    .inner_go(inner_go), .inner_base(inner_base),
    .commit_we(commit_we), .commit_addr(commit_addr), .key(key)
  );

  sort_inner_ctl #(.WIDTH(WIDTH), .AW(AW)) u_inner (
    .clk(clk), .rst_n(rst_n), .go(inner_go), .base(inner_base),
    .key(key), .rdata(mem_rdata), .rd_active(inner_run),
    .raddr(inner_raddr), .sh_we(sh_we), .sh_addr(sh_addr),
    .sh_data(sh_data), .wa(wa), .done(inner_done)
  );

  assign host_we = ld_en && !busy;

  always_comb begin
    mem_we    = 1'b1;
    mem_waddr = ld_addr;
    mem_wdata = ld_data;
    if (sh_we) begin
      mem_waddr = sh_addr;
      mem_wdata = sh_data;
    end else if (commit_we) begin
      mem_waddr = commit_addr;
      mem_wdata = key;
    end else begin
      mem_we = host_we;
    end
  end

  always_comb begin
    if (inner_run)  mem_raddr = inner_raddr;
    else if (fetch) mem_raddr = fetch_addr;
    else            mem_raddr = rd_addr;
  end

  sort_regfile #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );

  assign rd_data = mem_rdata;
endmodule

// File: rtl/sorter_chk.sv
module sorter_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             inner_run,
  input logic             sh_we,
  input logic             commit_we,
  input logic             host_we,
  input logic [WIDTH-1:0] sh_data,
  input logic [WIDTH-1:0] key
);
  // R9
  one_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sh_we, commit_we, host_we}));

  // R9
  shift_above_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sh_we |-> (sh_data > key));

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  inner_within_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inner_run |-> busy);
endmodule

bind insertion_sorter sorter_chk #(.WIDTH(WIDTH)) u_sorter_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .inner_run(inner_run), .sh_we(sh_we), .commit_we(commit_we),
  .host_we(host_we), .sh_data(sh_data), .key(key)
);

// File: tb/test_insertion_sorter.sv
`timescale 1ns/1ps
module test_insertion_sorter;
  localparam int WIDTH = 16;
  localparam int DEPTH = 16;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = AW + 1;

  logic             clk = 1'b0;
  logic             rst_n, ld_en, start, busy, done;
  logic [AW-1:0]    ld_addr, rd_addr;
  logic [WIDTH-1:0] ld_data, rd_data;
  logic [CW-1:0]    count;

  int n_cmp = 0;
  int n_bad = 0;
  int ref_mem [DEPTH];

  always #4 clk = ~clk;

  insertion_sorter #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_insertion_sorter (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr),
    .ld_data(ld_data), .count(count), .start(start), .busy(busy),
    .done(done), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic load_word(int a, int d);
    ld_en = 1'b1; ld_addr = AW'(a); ld_data = WIDTH'(d);
    @(negedge clk);
    ld_en = 1'b0;
    ref_mem[a] = d;
  endtask

  task automatic read_all(string req);
    for (int a = 0; a < DEPTH; a++) begin
      rd_addr = AW'(a);
      #1;
      chk(req, $sformatf("word %0d", a), 32'(rd_data), 32'(ref_mem[a]));
    end
  endtask

  // Model: busy length from inversion count, result from a queue sort.
  task automatic run_sort(int cnt, bit disturb, string req);
    int n, inv, lat;
    int q[$];
    n = (cnt > DEPTH) ? DEPTH : cnt;
    inv = 0;
    for (int p = 0; p < n; p++) begin
      q.push_back(ref_mem[p]);
      for (int r = p + 1; r < n; r++)
        if (ref_mem[p] > ref_mem[r]) inv++;
    end
    q.sort();
    for (int p = 0; p < n; p++) ref_mem[p] = q[p];
    lat = (n <= 1) ? 1 : 1 + 2 * (n - 1) + inv;
    count = CW'(cnt);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < lat; c++) begin
      chk("R5", "busy during sort", 32'(busy), 32'd1);
      chk("R6", "done during sort", 32'(done), 32'd0);
      if (disturb && c == 2) begin
        start = 1'b1; ld_en = 1'b1; ld_addr = '0; ld_data = '1;
      end
      @(negedge clk);
      start = 1'b0; ld_en = 1'b0;
    end
    chk("R5", "busy after sort", 32'(busy), 32'd0);
    chk("R6", "done pulse", 32'(done), 32'd1);
    @(negedge clk);
    chk("R6", "done width", 32'(done), 32'd0);
    chk(req, "idle after sort", 32'(busy), 32'd0);
    read_all(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ld_en = 1'b0; start = 1'b0;
    ld_addr = '0; ld_data = '0; rd_addr = '0; count = '0;
    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", 32'(busy), 32'd0);
    chk("R1", "done in reset", 32'(done), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "busy after reset", 32'(busy), 32'd0);
    chk("R1", "done after reset", 32'(done), 32'd0);

    // R2: fill and read back
    for (int a = 0; a < DEPTH; a++) load_word(a, int'($urandom_range(0, 65535)));
    read_all("R2");

    // R3 R5: ten random words
    run_sort(10, 1'b0, "R3");

    // R3 R5: single element and empty
    for (int a = 0; a < DEPTH; a++) load_word(a, int'($urandom_range(0, 65535)));
    run_sort(1, 1'b0, "R3");
    run_sort(0, 1'b0, "R5");

    // R5: already ascending, full depth
    for (int a = 0; a < DEPTH; a++) load_word(a, 100 + 3 * a);
    run_sort(DEPTH, 1'b0, "R5");

    // R3 R5: descending, every word travels to the bottom
    for (int a = 0; a < DEPTH; a++) load_word(a, 60000 - 7 * a);
    run_sort(DEPTH, 1'b0, "R3");

    // R4 R9: many equal values; strict compare keeps latency minimal
    for (int a = 0; a < DEPTH; a++) load_word(a, int'($urandom_range(0, 3)));
    run_sort(12, 1'b0, "R4");
    for (int a = 0; a < DEPTH; a++) load_word(a, 5);
    run_sort(DEPTH, 1'b0, "R9");

    // R7: start and load strobes injected mid-sort are ignored
    for (int a = 0; a < DEPTH; a++) load_word(a, int'($urandom_range(0, 65535)));
    run_sort(DEPTH, 1'b1, "R7");

    // R8: oversized count clamps to full depth
    for (int a = 0; a < DEPTH; a++) load_word(a, int'($urandom_range(0, 65535)));
    run_sort(DEPTH + 4, 1'b0, "R8");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule